// File: doc/BRIEF.md
# Guarded-Reload Watchdog

This block is a down-counting watchdog. Its 16-bit reload value is held in two byte registers. Software changes that value through a plain register write port. Those registers refuse every write unless a fixed four-write key sequence precedes it, so a runaway program cannot shorten or stretch the time-out by accident.

A refresh strobe reloads the counter from the reload value. It stands in for the processor's "kick the dog" operation. A tick enable paces the countdown. When the count reaches zero, the block raises one of three single-cycle requests:
- a reset request, when reset-on-expiry is selected and the device is running;
- a stop-recovery request, when reset-on-expiry is selected and the device is in stop mode;
- an exception request, when exception mode is selected.

Two sticky flags record watchdog-caused and stop-caused events until software clears them.

Top module: `wdog_guarded_top`

## Requirements
- R1: Reload-high sits at address 0 and reload-low at address 1. Software unlocks them by writing 0x55 and then 0xAA to address 0. After that, one write to address 0 sets the high byte, and the next write to address 1 sets the low byte.
- R2: The two key writes (0x55, 0xAA) leave the high reload byte unchanged.
- R3: A write to address 0 or 1 that does not match the next expected step is ignored and returns the key state machine to idle, so the sequence must restart from 0x55. A write to address 2 (status) neither advances nor breaks the sequence.
- R4: The reload value is {high byte, low byte}, with the high byte in bits 15:8. It is visible on `reload_value`.
- R5: A refresh copies the current reload value into the counter and takes priority over a tick in the same cycle. A refresh part-way through a countdown restarts the full period.
- R6: The counter decrements only in cycles where `tick_en` is 1. Expiry is the step from 1 to 0, and it produces a request that is high for exactly one cycle, in the cycle after that clock edge. The counter then stays at 0 and gives no further request until the next refresh.
- R7: With `rst_on_expire`=1 and `stop_mode`=0, expiry pulses `reset_req` and sets `flag_wd`.
- R8: With `rst_on_expire`=1 and `stop_mode`=1, expiry pulses `stop_recover_req` instead of `reset_req`, and sets both `flag_wd` and `flag_stop`.
- R9: With `rst_on_expire`=0, expiry pulses `exception_req` only and leaves both flags unchanged.
- R10: Synchronous reset sets the reload value and the counter to `RELOAD_INIT` (default 0x0040), clears all requests and flags, and puts the key state machine in idle.
- R11: The flags are sticky. A write to address 2 clears `flag_wd` when data bit 0 is 1 and clears `flag_stop` when data bit 1 is 1. A flag being set in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload-high, 1 reload-low, 2 status |
| wr_data | input | 8 | Write data |
| refresh | input | 1 | Reload the counter from the reload value |
| tick_en | input | 1 | Countdown enable for this cycle |
| stop_mode | input | 1 | Device is in stop mode |
| rst_on_expire | input | 1 | 1: reset or recovery on expiry; 0: exception |
| reload_value | output | 16 | Current reload value |
| reset_req | output | 1 | One-cycle reset request |
| stop_recover_req | output | 1 | One-cycle stop-recovery request |
| exception_req | output | 1 | One-cycle exception request |
| flag_wd | output | 1 | Sticky watchdog-event flag |
| flag_stop | output | 1 | Sticky stop-recovery flag |

## Verification
A key state machine left in the wrong state appears at the next reload-register write. Either `reload_value` changes when it must not, or it fails to change one write after a complete sequence. The vector walk therefore probes each break point of the sequence and checks the reload value after every single write.

A counter error appears as an expiry one or more cycles away from the expected count. The bench counts edges from the refresh to the pulse. An event-routing error appears in the same cycle as expiry, as the wrong request line or a wrong flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_SAW_FIRST,
        LK_OPEN_HI,
        LK_OPEN_LO
    } lock_state_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic rst;
        logic recov;
        logic exc;
    } expire_req_t;

    function automatic logic hits(input reg_wr_t w, input logic [ADDR_W-1:0] a);
        return w.en && (w.addr == a);
    endfunction

endpackage

// File: rtl/wdog_reload_guard.sv
module wdog_reload_guard
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h0040
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    output logic [CNT_W-1:0] reload
);

    lock_state_e       st_q, st_d;
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic              hi_we, lo_we, hi_acc, lo_acc;

    assign hi_acc = hits(wr, ADDR_HI);
    assign lo_acc = hits(wr, ADDR_LO);

    always_comb begin
        st_d  = st_q;
        hi_we = 1'b0;
        lo_we = 1'b0;
        unique case (st_q)
            LK_IDLE: begin
                if (hi_acc && wr.data == KEY_FIRST) st_d = LK_SAW_FIRST;
            end
            LK_SAW_FIRST: begin
                if (hi_acc && wr.data == KEY_SECOND) st_d = LK_OPEN_HI;
                else if (hi_acc || lo_acc)          st_d = LK_IDLE;
            end
            LK_OPEN_HI: begin
                if (hi_acc) begin
                    hi_we = 1'b1;
                    st_d  = LK_OPEN_LO;
                end else if (lo_acc) begin
                    st_d = LK_IDLE;
                end
            end
            LK_OPEN_LO: begin
                if (lo_acc) begin
                    lo_we = 1'b1;
                    st_d  = LK_IDLE;
                end else if (hi_acc) begin
                    st_d = LK_IDLE;
                end
            end
            default: st_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LK_IDLE;
            hi_q <= RELOAD_INIT[CNT_W-1:BYTE_W];
            lo_q <= RELOAD_INIT[BYTE_W-1:0];
        end else begin
            st_q <= st_d;
            if (hi_we) hi_q <= wr.data;
            if (lo_we) lo_q <= wr.data;
        end
    end

    assign reload = {hi_q, lo_q};

    assert_hi_guarded_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q != LK_OPEN_HI) |=> $stable(hi_q));
    assert_lo_guarded_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q != LK_OPEN_LO) |=> $stable(lo_q));
    assert_key_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (hi_acc && (wr.data == KEY_FIRST || wr.data == KEY_SECOND) &&
         (st_q == LK_IDLE || st_q == LK_SAW_FIRST)) |=> $stable(hi_q));
    assert_hi_takes_data_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_OPEN_HI && hi_acc) |=> (hi_q == $past(wr.data)));

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h0040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             refresh,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             running;

    assign running = (cnt_q != '0);
    assign expire  = tick && !refresh && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= RELOAD_INIT;
        else if (refresh)         cnt_q <= reload;
        else if (tick && running) cnt_q <= cnt_q - ONE;
    end

    assert_refresh_loads_R5: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (cnt_q == $past(reload)));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!refresh && !tick) |=> $stable(cnt_q));
    assert_zero_parks_R6: assert property (@(posedge clk) disable iff (rst)
        (!refresh && cnt_q == '0) |=> (cnt_q == '0));
    assert_expire_lands_zero_R6: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_event.sv
module wdog_event
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        expire,
    input  logic        rst_sel,
    input  logic        stop_mode,
    input  logic        clr_wd,
    input  logic        clr_stop,
    output expire_req_t req,
    output logic        flag_wd,
    output logic        flag_stop
);

    expire_req_t req_d;
    logic        set_wd, set_stop;

    always_comb begin
        req_d.rst   = expire && rst_sel && !stop_mode;
        req_d.recov = expire && rst_sel && stop_mode;
        req_d.exc   = expire && !rst_sel;
    end

    assign set_wd   = expire && rst_sel;
    assign set_stop = expire && rst_sel && stop_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= '0;
            flag_wd   <= 1'b0;
            flag_stop <= 1'b0;
        end else begin
            req <= req_d;
            if (set_wd)      flag_wd <= 1'b1;
            else if (clr_wd) flag_wd <= 1'b0;
            if (set_stop)      flag_stop <= 1'b1;
            else if (clr_stop) flag_stop <= 1'b0;
        end
    end

    assert_one_req_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.rst, req.recov, req.exc}));
    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        req.rst |=> !req.rst);
    assert_rst_flags_R7: assert property (@(posedge clk) disable iff (rst)
        req.rst |-> flag_wd);
    assert_recov_flags_R8: assert property (@(posedge clk) disable iff (rst)
        req.recov |-> (flag_wd && flag_stop));
    assert_exc_no_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (expire && !rst_sel && !clr_wd) |=> (flag_wd == $past(flag_wd)));

endmodule

// File: rtl/wdog_guarded_top.sv
module wdog_guarded_top
    import wdog_pkg::*;
#(
    parameter logic [15:0] RELOAD_INIT = 16'h0040
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        refresh,
    input  logic        tick_en,
    input  logic        stop_mode,
    input  logic        rst_on_expire,
    output logic [15:0] reload_value,
    output logic        reset_req,
    output logic        stop_recover_req,
    output logic        exception_req,
    output logic        flag_wd,
    output logic        flag_stop
);

    reg_wr_t     wr;
    expire_req_t req;
    logic        expire, stat_wr;

    assign wr      = '{en: wr_en, addr: wr_addr, data: wr_data};
    assign stat_wr = hits(wr, ADDR_STAT);

    wdog_reload_guard #(.RELOAD_INIT(RELOAD_INIT)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .reload (reload_value)
    );

    wdog_countdown #(.RELOAD_INIT(RELOAD_INIT)) u_count (
        .clk     (clk),
        .rst     (rst),
        .refresh (refresh),
        .tick    (tick_en),
        .reload  (reload_value),
        .expire  (expire)
    );

    wdog_event u_event (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .rst_sel   (rst_on_expire),
        .stop_mode (stop_mode),
        .clr_wd    (stat_wr && wr_data[0]),
        .clr_stop  (stat_wr && wr_data[1]),
        .req       (req),
        .flag_wd   (flag_wd),
        .flag_stop (flag_stop)
    );

    assign reset_req        = req.rst;
    assign stop_recover_req = req.recov;
    assign exception_req    = req.exc;

endmodule

// File: tb/sim_wdog_guarded_top.sv
module sim_wdog_guarded_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        refresh = 1'b0;
    logic        tick_en = 1'b0;
    logic        stop_mode = 1'b0;
    logic        rst_on_expire = 1'b1;
    logic [15:0] reload_value;
    logic        reset_req, stop_recover_req, exception_req, flag_wd, flag_stop;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdog_guarded_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .refresh(refresh), .tick_en(tick_en), .stop_mode(stop_mode),
        .rst_on_expire(rst_on_expire), .reload_value(reload_value),
        .reset_req(reset_req), .stop_recover_req(stop_recover_req),
        .exception_req(exception_req), .flag_wd(flag_wd), .flag_stop(flag_stop)
    );

    // {addr, data, expected reload after the write}
    localparam int NV = 28;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 8'h55, 16'h0040}, {2'd0, 8'hAA, 16'h0040},
        {2'd0, 8'h12, 16'h1240}, {2'd1, 8'h34, 16'h1234},
        {2'd0, 8'h77, 16'h1234}, {2'd1, 8'h99, 16'h1234},
        {2'd0, 8'h55, 16'h1234}, {2'd1, 8'h01, 16'h1234},
        {2'd0, 8'hAA, 16'h1234}, {2'd0, 8'h00, 16'h1234},
        {2'd0, 8'h55, 16'h1234}, {2'd0, 8'h55, 16'h1234},
        {2'd0, 8'hAA, 16'h1234}, {2'd0, 8'h00, 16'h1234},
        {2'd0, 8'h55, 16'h1234}, {2'd0, 8'hAA, 16'h1234},
        {2'd1, 8'h07, 16'h1234}, {2'd0, 8'h00, 16'h1234},
        {2'd0, 8'h55, 16'h1234}, {2'd0, 8'hAA, 16'h1234},
        {2'd0, 8'h00, 16'h0034}, {2'd0, 8'h05, 16'h0034},
        {2'd1, 8'h10, 16'h0034}, {2'd0, 8'h55, 16'h0034},
        {2'd2, 8'h00, 16'h0034}, {2'd0, 8'hAA, 16'h0034},
        {2'd0, 8'h00, 16'h0034}, {2'd1, 8'h08, 16'h0008}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_refresh();
        @(negedge clk);
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic run_to_expire(output int n, output logic [2:0] seen);
        n = 0; seen = '0;
        for (int i = 1; i <= 300; i++) begin
            @(posedge clk); #2;
            if (reset_req | stop_recover_req | exception_req) begin
                n = i;
                seen = {reset_req, stop_recover_req, exception_req};
                break;
            end
        end
    endtask

    task automatic quiet_edges(input int k, input string tag);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #2;
            check(!(reset_req | stop_recover_req | exception_req), tag,
                  {reset_req, stop_recover_req, exception_req}, 0);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        int n;
        logic [2:0] seen;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(reload_value == 16'h0040, "R10 reload init", reload_value, 16'h0040);
        check({reset_req, stop_recover_req, exception_req, flag_wd, flag_stop} == 0,
              "R10 outputs clear", {reset_req, stop_recover_req, exception_req, flag_wd, flag_stop}, 0);
        rst = 1'b0; tick_en = 1'b1;
        // R10/R7: counter starts from its reset value
        run_to_expire(n, seen);
        check(n == 64, "R10 reset count", n, 64);
        check(seen == 3'b100, "R7 reset request", seen, 3'b100);
        check(flag_wd && !flag_stop, "R7 flags", {flag_wd, flag_stop}, 2'b10);
        @(posedge clk); #2;
        check(!reset_req, "R6 one-cycle pulse", reset_req, 0);
        tick_en = 1'b0;
        reg_write(2'd2, 8'h01);
        check(!flag_wd, "R11 clear wd", flag_wd, 0);

        // R1..R4: key sequence table
        for (int v = 0; v < NV; v++) begin
            reg_write(VEC[v][25:24], VEC[v][23:16]);
            check(reload_value == VEC[v][15:0], $sformatf("R1/R2/R3/R4 vec %0d", v),
                  reload_value, VEC[v][15:0]);
        end

        // R5/R7: period from new reload, R6 parks at zero
        tick_en = 1'b1;
        do_refresh();
        run_to_expire(n, seen);
        check(n == 8, "R5 period", n, 8);
        check(seen == 3'b100, "R7 request", seen, 3'b100);
        quiet_edges(20, "R6 no repeat");
        check(flag_wd, "R11 sticky", flag_wd, 1);

        // R8: stop mode
        reg_write(2'd2, 8'h03);
        stop_mode = 1'b1;
        do_refresh();
        run_to_expire(n, seen);
        check(n == 8 && seen == 3'b010, "R8 recovery", {n[7:0], 5'd0, seen}, {8'd8, 5'd0, 3'b010});
        check(flag_wd && flag_stop, "R8 flags", {flag_wd, flag_stop}, 2'b11);
        reg_write(2'd2, 8'h02);
        check(flag_wd && !flag_stop, "R11 clear stop only", {flag_wd, flag_stop}, 2'b10);

        // R9: exception mode
        reg_write(2'd2, 8'h03);
        stop_mode = 1'b0; rst_on_expire = 1'b0;
        do_refresh();
        run_to_expire(n, seen);
        check(n == 8 && seen == 3'b001, "R9 exception", {n[7:0], 5'd0, seen}, {8'd8, 5'd0, 3'b001});
        check(!flag_wd && !flag_stop, "R9 no flags", {flag_wd, flag_stop}, 0);

        // R5: refresh mid-count restarts
        rst_on_expire = 1'b1;
        do_refresh();
        quiet_edges(5, "R5 early");
        do_refresh();
        run_to_expire(n, seen);
        check(n == 8, "R5 restart", n, 8);

        // R6: no ticks, no countdown
        tick_en = 1'b0;
        do_refresh();
        quiet_edges(12, "R6 gated");
        tick_en = 1'b1;
        run_to_expire(n, seen);
        check(n == 8, "R6 gated then run", n, 8);

        // R11: set wins over clear in the same cycle
        reg_write(2'd2, 8'h01);
        check(!flag_wd, "R11 cleared", flag_wd, 0);
        do_refresh();
        repeat (7) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        @(posedge clk); #2;
        check(reset_req, "R11 expiry edge", reset_req, 1);
        check(flag_wd, "R11 set beats clear", flag_wd, 1);
        @(negedge clk);
        wr_en = 1'b0;
        finish_up();
    end

endmodule